// File: doc/BRIEF.md
# Front-Panel Toggle Memory Controller

This block lets an operator inspect and fill a small static RAM by hand, with no processor in the system. Toggle switches present an 11-bit address and an 8-bit data value; two already-debounced single-cycle button strobes, one for depositing a byte and one for examining a byte, tell the block what to do. From each strobe the block produces the active-low select, write and output-enable controls of a 2048 x 8 RAM, which is modelled inside the block.

Two display registers drive the indicator outputs. One shows the address most recently selected by either button. The other shows the byte most recently fetched from the RAM. While a byte is fetched, the switch data drivers are taken off the shared data bus so that they never fight the RAM output.

Top module: `panel_mem_ctrl`

## Requirements
- R1: The RAM holds 2048 bytes. On a clock edge where a write strobe is accepted, the switch data byte is stored at the switch address. A later read of that address returns that byte.
- R2: In a cycle with the write strobe high, `ram_cs_n`=0, `ram_we_n`=0 and `ram_oe_n`=1.
- R3: In a cycle with only the read strobe high, `ram_cs_n`=0, `ram_oe_n`=0 and `ram_we_n`=1.
- R4: After the edge that ends a read cycle, `data_disp` equals the byte stored at the address that was read.
- R5: After the edge that ends any accepted write or read, `addr_disp` equals the switch address that was applied in that cycle.
- R6: When both strobes are high in the same cycle, the write is performed (R1, R2) and the read is dropped, so `data_disp` keeps its previous value.
- R7: A write leaves `data_disp` unchanged, because the data display shows only fetched bytes.
- R8: With neither strobe high, all three RAM controls are 1 and both displays keep their values.
- R9: During a read cycle `sw_drive_en`=0 and `data_bus` carries the RAM output. In every other cycle `sw_drive_en`=1 and `data_bus` carries the switch data.
- R10: While `rst` is high, and in the first cycle after it falls, both displays are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sw_addr | input | 11 | Address switches |
| sw_data | input | 8 | Data switches |
| wr_btn | input | 1 | Deposit strobe, one cycle per press |
| rd_btn | input | 1 | Examine strobe, one cycle per press |
| ram_cs_n | output | 1 | RAM chip select, active low |
| ram_we_n | output | 1 | RAM write enable, active low |
| ram_oe_n | output | 1 | RAM output enable, active low |
| sw_drive_en | output | 1 | Switch data drivers connected to the bus |
| data_bus | output | 8 | Value on the shared data bus |
| addr_disp | output | 11 | Address indicator register |
| data_disp | output | 8 | Data indicator register |

## Verification
Every cycle, the assertions check the control patterns for each strobe combination, that the switch drivers and the RAM never drive the bus together, that the address display follows the accepted address, and that the displays hold when no strobe is given or when a write is done. Only the bench scenarios can show that the memory contents are correct: that a byte read back equals the byte deposited earlier, including at the lowest and highest address, and across mixed random sequences against a reference memory. The clearing of the displays on reset is also checked by the bench.

// File: rtl/panel_pkg.sv
package panel_pkg;

    localparam int ADDR_W = 11;
    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        CMD_IDLE  = 2'd0,
        CMD_WRITE = 2'd1,
        CMD_READ  = 2'd2
    } panel_cmd_e;

    typedef struct packed {
        logic cs_n;
        logic we_n;
        logic oe_n;
    } ram_ctrl_t;

    // Write has priority over read when both buttons strobe together.
    function automatic panel_cmd_e pick_cmd(input logic wr, input logic rd);
        if (wr)      return CMD_WRITE;
        else if (rd) return CMD_READ;
        else         return CMD_IDLE;
    endfunction

    function automatic ram_ctrl_t ctrl_for(input panel_cmd_e cmd);
        ram_ctrl_t c;
        c = '{cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1};
        case (cmd)
            CMD_WRITE: begin c.cs_n = 1'b0; c.we_n = 1'b0; end
            CMD_READ:  begin c.cs_n = 1'b0; c.oe_n = 1'b0; end
            default:   ;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/panel_cmd_decode.sv
module panel_cmd_decode
    import panel_pkg::*;
(
    input  logic       wr_btn,
    input  logic       rd_btn,
    output panel_cmd_e cmd,
    output ram_ctrl_t  ctrl,
    output logic       sw_en
);

    always_comb begin
        cmd   = pick_cmd(wr_btn, rd_btn);
        ctrl  = ctrl_for(cmd);
        sw_en = (cmd != CMD_READ);
    end

    // R6: simultaneous strobes resolve to a write
    always_comb begin
        if (wr_btn && rd_btn)
            a_r6_write_wins: assert (cmd == CMD_WRITE);
    end

endmodule

// File: rtl/panel_sram.sv
module panel_sram #(
    parameter int AW = 11,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          cs_n,
    input  logic          we_n,
    input  logic          oe_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          drive
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (!cs_n && !we_n)
            mem[addr] <= din;
    end

    always_comb begin
        dout  = mem[addr];
        drive = !cs_n && !oe_n && we_n;
    end

endmodule

// File: rtl/panel_disp_latch.sv
module panel_disp_latch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         le,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (le)
            q <= d;
    end

    // R8: value holds whenever the enable is low
    a_r8_latch_hold: assert property (@(posedge clk) disable iff (rst)
        !le |=> $stable(q));

endmodule

// File: rtl/panel_mem_ctrl.sv
module panel_mem_ctrl
    import panel_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] sw_addr,
    input  logic [DATA_W-1:0] sw_data,
    input  logic              wr_btn,
    input  logic              rd_btn,
    output logic              ram_cs_n,
    output logic              ram_we_n,
    output logic              ram_oe_n,
    output logic              sw_drive_en,
    output logic [DATA_W-1:0] data_bus,
    output logic [ADDR_W-1:0] addr_disp,
    output logic [DATA_W-1:0] data_disp
);

    panel_cmd_e        cmd;
    ram_ctrl_t         ctrl;
    logic              sw_en;
    logic [DATA_W-1:0] ram_q;
    logic              ram_drv;

    panel_cmd_decode u_dec (
        .wr_btn (wr_btn),
        .rd_btn (rd_btn),
        .cmd    (cmd),
        .ctrl   (ctrl),
        .sw_en  (sw_en)
    );

    panel_sram #(.AW(ADDR_W), .DW(DATA_W)) u_ram (
        .clk   (clk),
        .cs_n  (ctrl.cs_n),
        .we_n  (ctrl.we_n),
        .oe_n  (ctrl.oe_n),
        .addr  (sw_addr),
        .din   (data_bus),
        .dout  (ram_q),
        .drive (ram_drv)
    );

    always_comb begin
        ram_cs_n    = ctrl.cs_n;
        ram_we_n    = ctrl.we_n;
        ram_oe_n    = ctrl.oe_n;
        sw_drive_en = sw_en;
        if (sw_en)        data_bus = sw_data;
        else if (ram_drv) data_bus = ram_q;
        else              data_bus = '0;
    end

    panel_disp_latch #(.W(ADDR_W)) u_addr_latch (
        .clk (clk),
        .rst (rst),
        .le  (cmd != CMD_IDLE),
        .d   (sw_addr),
        .q   (addr_disp)
    );

    panel_disp_latch #(.W(DATA_W)) u_data_latch (
        .clk (clk),
        .rst (rst),
        .le  (cmd == CMD_READ),
        .d   (data_bus),
        .q   (data_disp)
    );

    a_r2_write_ctrl: assert property (@(posedge clk) disable iff (rst)
        wr_btn |-> (!ram_cs_n && !ram_we_n && ram_oe_n));

    a_r3_read_ctrl: assert property (@(posedge clk) disable iff (rst)
        (rd_btn && !wr_btn) |-> (!ram_cs_n && !ram_oe_n && ram_we_n));

    a_r8_idle_ctrl: assert property (@(posedge clk) disable iff (rst)
        (!rd_btn && !wr_btn) |-> (ram_cs_n && ram_we_n && ram_oe_n));

    a_r9_no_contention: assert property (@(posedge clk) disable iff (rst)
        !(sw_drive_en && ram_drv));

    a_r9_gate_on_read: assert property (@(posedge clk) disable iff (rst)
        !ram_oe_n |-> !sw_drive_en);

    a_r5_addr_follow: assert property (@(posedge clk) disable iff (rst)
        (wr_btn || rd_btn) |=> (addr_disp == $past(sw_addr)));

    a_r7_write_keeps_data: assert property (@(posedge clk) disable iff (rst)
        wr_btn |=> $stable(data_disp));

endmodule

// File: tb/panel_mem_ctrl_test.sv
module panel_mem_ctrl_test;

    logic        clk = 1'b0;
    logic        rst;
    logic [10:0] sw_addr;
    logic [7:0]  sw_data;
    logic        wr_btn;
    logic        rd_btn;
    logic        ram_cs_n, ram_we_n, ram_oe_n, sw_drive_en;
    logic [7:0]  data_bus;
    logic [10:0] addr_disp;
    logic [7:0]  data_disp;

    int n_cmp = 0;
    int n_bad = 0;

    logic [7:0]  ref_mem [2048];
    logic [10:0] exp_addr;
    logic [7:0]  exp_data;

    always #5 clk = ~clk;

    panel_mem_ctrl uut (
        .clk(clk), .rst(rst), .sw_addr(sw_addr), .sw_data(sw_data),
        .wr_btn(wr_btn), .rd_btn(rd_btn), .ram_cs_n(ram_cs_n),
        .ram_we_n(ram_we_n), .ram_oe_n(ram_oe_n), .sw_drive_en(sw_drive_en),
        .data_bus(data_bus), .addr_disp(addr_disp), .data_disp(data_disp)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [2:0] exp_ctrl(input logic w, input logic r);
        if (w)      return 3'b001;   // {cs_n, we_n, oe_n}
        else if (r) return 3'b010;
        else        return 3'b111;
    endfunction

    // Called at a falling edge: drive, check the same-cycle outputs,
    // cross the rising edge, then check the display registers.
    task automatic op(input logic w, input logic r, input logic [10:0] a, input logic [7:0] d);
        logic [2:0] ec;
        wr_btn = w; rd_btn = r; sw_addr = a; sw_data = d;
        #1;
        ec = exp_ctrl(w, r);
        if (w)
            chk({ram_cs_n, ram_we_n, ram_oe_n} == ec, "R2 write ctrl", {ram_cs_n, ram_we_n, ram_oe_n}, ec);
        else if (r)
            chk({ram_cs_n, ram_we_n, ram_oe_n} == ec, "R3 read ctrl", {ram_cs_n, ram_we_n, ram_oe_n}, ec);
        else
            chk({ram_cs_n, ram_we_n, ram_oe_n} == ec, "R8 idle ctrl", {ram_cs_n, ram_we_n, ram_oe_n}, ec);
        if (r && !w) begin
            chk(sw_drive_en == 1'b0, "R9 switch gated", sw_drive_en, 0);
            chk(data_bus == ref_mem[a], "R9 bus carries ram", data_bus, ref_mem[a]);
        end else begin
            chk(sw_drive_en == 1'b1, "R9 switch drives", sw_drive_en, 1);
            chk(data_bus == d, "R9 bus carries switch", data_bus, d);
        end
        @(posedge clk);
        if (w) begin
            ref_mem[a] = d;
            exp_addr = a;
        end else if (r) begin
            exp_data = ref_mem[a];
            exp_addr = a;
        end
        @(negedge clk);
        if (w || r)
            chk(addr_disp == exp_addr, "R5 addr display", addr_disp, exp_addr);
        else
            chk(addr_disp == exp_addr, "R8 addr hold", addr_disp, exp_addr);
        if (r && !w)
            chk(data_disp == exp_data, "R4 R1 data display", data_disp, exp_data);
        else if (w && r)
            chk(data_disp == exp_data, "R6 read dropped", data_disp, exp_data);
        else if (w)
            chk(data_disp == exp_data, "R7 write keeps data", data_disp, exp_data);
        else
            chk(data_disp == exp_data, "R8 data hold", data_disp, exp_data);
        wr_btn = 1'b0; rd_btn = 1'b0;
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog actual=0x0 expected=0x1");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; wr_btn = 1'b0; rd_btn = 1'b0; sw_addr = '0; sw_data = '0;
        exp_addr = '0; exp_data = '0;
        repeat (3) @(negedge clk);
        chk(addr_disp == 0, "R10 addr reset", addr_disp, 0);
        chk(data_disp == 0, "R10 data reset", data_disp, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(addr_disp == 0 && data_disp == 0, "R10 after release", {addr_disp, data_disp}, 0);

        // Preload the low 64 addresses and both ends of the array.
        for (int i = 0; i < 64; i++) op(1'b1, 1'b0, 11'(i), 8'($urandom));
        op(1'b1, 1'b0, 11'h7FF, 8'hA5);
        op(1'b1, 1'b0, 11'h000, 8'h3C);
        op(1'b0, 1'b1, 11'h7FF, 8'h00);     // R1 top address
        op(1'b0, 1'b0, 11'h123, 8'hFF);     // R8 idle hold
        op(1'b0, 1'b1, 11'h000, 8'hFF);     // R1 bottom address
        op(1'b1, 1'b1, 11'h005, 8'h77);     // R6 both strobes
        op(1'b0, 1'b1, 11'h005, 8'h00);     // R6 write took effect
        op(1'b1, 1'b0, 11'h7FF, 8'h5A);     // R7 write keeps data display
        op(1'b0, 1'b1, 11'h7FF, 8'h00);

        // Random mix over the preloaded range.
        for (int k = 0; k < 600; k++) begin
            int sel;
            logic [10:0] a;
            sel = $urandom_range(0, 9);
            a = 11'($urandom_range(0, 63));
            if (sel < 3)      op(1'b1, 1'b0, a, 8'($urandom));
            else if (sel < 7) op(1'b0, 1'b1, a, 8'($urandom));
            else if (sel < 8) op(1'b1, 1'b1, a, 8'($urandom));
            else              op(1'b0, 1'b0, 11'($urandom), 8'($urandom));
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule